// File: doc/BRIEF.md
# Bulk-Erase Flash Command Decoder

This block sits between the asynchronous byte-wide bus of a bulk-erase flash device and its embedded-algorithm engine. It watches the chip-enable, write-enable and output-enable strobes (all active low) and brings them into the system clock domain. It recognises bus write cycles and decodes one-cycle and two-cycle commands. From those it drives a mode code, a one-clock erase launch, and a one-clock program launch that carries the latched address and data. The engine can only be commanded while the programming-voltage qualifier is high. A supply-lockout input forces read mode and blocks all writes.

A write cycle is a period where chip enable and write enable are both low and output enable is high. The address is taken when the cycle opens, which is the later of the two falling strobes. The data is taken when the cycle closes, which is the earlier of the two rising strobes. The cycle must last at least `MIN_PULSE` clocks after synchronisation, or it is discarded as a glitch.

A small byte array stands in for the memory so that effects can be read back. Erase sets every byte to FFh. Program ANDs the data into the addressed byte, because cells only go from 1 to 0. Reads return the array, or the identifier codes while in identify mode. The qualifier and lockout inputs are taken to be synchronous to the clock already.

Top module: `bulkflash_cmd_ctrl`

## Requirements
- R1: While `hv_ok` is low, `mode_o` is forced to 00 (read) and every write cycle is ignored: no launch pulse and no mode change.
- R2: A write of 00h or FFh selects read mode (`mode_o`=00). A read then returns the array byte at address bits [log2(DEPTH)-1:0]. The array holds FFh out of reset.
- R3: A write of 80h or 90h selects identify mode (`mode_o`=01). In that mode, a read of address 0 returns `MFR_CODE` (01h), a read of address 1 returns `DEV_CODE` (25h), and any other address returns 00h.
- R4: A first 30h write gives `mode_o`=10 and launches nothing. Only a second consecutive 30h produces one `erase_go` pulse, after which every byte reads FFh and `mode_o`=00. Any other write in that state returns to read mode with no erase.
- R5: A write of 10h or 50h gives `mode_o`=11. The next accepted write produces one `prog_go` pulse carrying that cycle's address and data, and returns `mode_o` to 00. The addressed byte becomes old AND data.
- R6: The address is sampled when a write cycle opens. The data is sampled when it closes. An address change inside the cycle is ignored, while a data change inside the cycle is what gets used.
- R7: A cycle counts only when CE and WE are low and OE is high throughout. A cycle where OE is low, or where CE stays high, has no effect.
- R8: After program setup, a first FFh write is consumed as program data: the array is unchanged and the mode returns to 00. A second FFh keeps read mode.
- R9: While `vlow` is high, `mode_o` is 00 and all writes are ignored.
- R10: A write cycle already in progress when reset is released is not taken as a command when it ends.
- R11: A write-enable low pulse shorter than `MIN_PULSE` synchronised clocks is discarded.
- R12: An unrecognised code returns `mode_o` to 00 without any launch pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| hv_ok | input | 1 | Programming-voltage qualifier, high when commands are allowed |
| vlow | input | 1 | Supply-lockout flag, high while supply is too low |
| ce_n | input | 1 | Asynchronous chip enable, active low |
| we_n | input | 1 | Asynchronous write enable, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | AW | Bus address |
| din | input | DW | Bus write data |
| dout | output | DW | Read data, 00h when not selected for read |
| mode_o | output | 2 | 00 read, 01 identify, 10 erase armed, 11 program armed |
| erase_go | output | 1 | One-clock erase launch |
| prog_go | output | 1 | One-clock program launch |
| prog_addr | output | AW | Address for the program launch |
| prog_data | output | DW | Data for the program launch |

## Verification
The bench builds the block with its defaults: a 16-byte array, a two-clock minimum pulse and two synchroniser stages. The small array lets every byte be read back after an erase, and lets random program traffic hit the same bytes often, which exposes the AND behaviour. With a two-clock minimum, a single-clock write-enable dip is exactly the glitch case. The short synchroniser keeps each bus cycle to a dozen clocks, so a long random command mix fits in the run.

// File: rtl/bfc_pkg.sv
package bfc_pkg;
   typedef enum logic [1:0] {
      M_READ    = 2'b00,
      M_IDENT   = 2'b01,
      M_ERS_ARM = 2'b10,
      M_PGM_ARM = 2'b11
   } bfc_mode_e;

   localparam logic [7:0] C_RD_A  = 8'h00;
   localparam logic [7:0] C_RD_B  = 8'hFF;
   localparam logic [7:0] C_ID_A  = 8'h80;
   localparam logic [7:0] C_ID_B  = 8'h90;
   localparam logic [7:0] C_ERS   = 8'h30;
   localparam logic [7:0] C_PGM_A = 8'h10;
   localparam logic [7:0] C_PGM_B = 8'h50;

   function automatic bfc_mode_e decode_cmd(input logic [7:0] c);
      case (c)
         C_ID_A, C_ID_B:   decode_cmd = M_IDENT;
         C_ERS:            decode_cmd = M_ERS_ARM;
         C_PGM_A, C_PGM_B: decode_cmd = M_PGM_ARM;
         default:          decode_cmd = M_READ;
      endcase
   endfunction
endpackage

// File: rtl/bfc_sync.sv
module bfc_sync #(
   parameter int             W      = 3,
   parameter int             STAGES = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] pipe [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[0] <= RST_VAL;
      else        pipe[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe[s] <= RST_VAL;
         else        pipe[s] <= pipe[s-1];
      end
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/bfc_wr_capture.sv
module bfc_wr_capture #(
   parameter int AW        = 16,
   parameter int DW        = 8,
   parameter int MIN_PULSE = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ce_s,
   input  logic          we_s,
   input  logic          oe_s,
   input  logic          lock,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] din,
   output logic          wr_stb,
   output logic [AW-1:0] wr_addr,
   output logic [DW-1:0] wr_data
);
   localparam int CW = $clog2(MIN_PULSE + 1);
   localparam logic [CW-1:0] MIN_C = CW'(MIN_PULSE);

   logic          act, act_q, armed, live;
   logic [CW-1:0] cnt;
   logic [AW-1:0] addr_lat;

   assign act = ~ce_s & ~we_s & oe_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q    <= 1'b1;
         armed    <= 1'b0;
         live     <= 1'b0;
         cnt      <= '0;
         addr_lat <= '0;
         wr_stb   <= 1'b0;
         wr_addr  <= '0;
         wr_data  <= '0;
      end else begin
         act_q  <= act;
         wr_stb <= 1'b0;
         if (lock)     armed <= 1'b0;
         else if (!act) armed <= 1'b1;
         if (act && !act_q) begin
            addr_lat <= addr;
            cnt      <= CW'(1);
            live     <= armed && !lock;
         end else if (act && cnt < MIN_C) begin
            cnt <= cnt + CW'(1);
         end
         if (lock) live <= 1'b0;
         if (act_q && !act) begin
            if (live && oe_s && cnt >= MIN_C && !lock) begin
               wr_stb  <= 1'b1;
               wr_addr <= addr_lat;
               wr_data <= din;
            end
            live <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/bfc_cmd_decode.sv
module bfc_cmd_decode
   import bfc_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hv_ok,
   input  logic          lock,
   input  logic          wr_stb,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   output bfc_mode_e     mode,
   output logic          erase_go,
   output logic          prog_go,
   output logic [AW-1:0] prog_addr,
   output logic [DW-1:0] prog_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode      <= M_READ;
         erase_go  <= 1'b0;
         prog_go   <= 1'b0;
         prog_addr <= '0;
         prog_data <= '0;
      end else begin
         erase_go <= 1'b0;
         prog_go  <= 1'b0;
         if (!hv_ok || lock) begin
            mode <= M_READ;
         end else if (wr_stb) begin
            case (mode)
               M_PGM_ARM: begin
                  prog_go   <= 1'b1;
                  prog_addr <= wr_addr;
                  prog_data <= wr_data;
                  mode      <= M_READ;
               end
               M_ERS_ARM: begin
                  erase_go <= (wr_data[7:0] == C_ERS);
                  mode     <= M_READ;
               end
               default: mode <= decode_cmd(wr_data[7:0]);
            endcase
         end
      end
   end
endmodule

// File: rtl/bfc_array_model.sv
module bfc_array_model #(
   parameter int DW    = 8,
   parameter int DEPTH = 16,
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          erase_go,
   input  logic          prog_go,
   input  logic [IW-1:0] prog_idx,
   input  logic [DW-1:0] prog_data,
   input  logic [IW-1:0] rd_idx,
   output logic [DW-1:0] rd_data
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      end else if (erase_go) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      end else if (prog_go) begin
         mem[prog_idx] <= mem[prog_idx] & prog_data;
      end
   end

   assign rd_data = mem[rd_idx];
endmodule

// File: rtl/bulkflash_cmd_ctrl.sv
module bulkflash_cmd_ctrl
   import bfc_pkg::*;
#(
   parameter int          AW          = 16,
   parameter int          DW          = 8,
   parameter int          DEPTH       = 16,
   parameter int          MIN_PULSE   = 2,
   parameter int          SYNC_STAGES = 2,
   parameter logic [7:0]  MFR_CODE    = 8'h01,
   parameter logic [7:0]  DEV_CODE    = 8'h25
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hv_ok,
   input  logic          vlow,
   input  logic          ce_n,
   input  logic          we_n,
   input  logic          oe_n,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] dout,
   output logic [1:0]    mode_o,
   output logic          erase_go,
   output logic          prog_go,
   output logic [AW-1:0] prog_addr,
   output logic [DW-1:0] prog_data
);
   localparam int IW = $clog2(DEPTH);

   initial begin
      if (DW != 8)                 $fatal(1, "command path needs byte data");
      if (DEPTH < 2 || (1 << IW) != DEPTH) $fatal(1, "DEPTH must be a power of two");
      if (IW > AW)                 $fatal(1, "DEPTH exceeds address space");
      if (MIN_PULSE < 1)           $fatal(1, "MIN_PULSE must be at least 1");
      if (SYNC_STAGES < 2)         $fatal(1, "SYNC_STAGES must be at least 2");
   end

   logic [2:0]    strobe_s;
   logic          ce_s, we_s, oe_s;
   logic          wr_stb;
   logic [AW-1:0] wr_addr;
   logic [DW-1:0] wr_data;
   bfc_mode_e     mode;
   logic [DW-1:0] arr_rd;
   logic [DW-1:0] rd_mux;

   // reset value looks like a write in progress, so a cycle open at power-up is never armed
   bfc_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({ce_n, we_n, oe_n}), .q(strobe_s)
   );
   assign ce_s = strobe_s[2];
   assign we_s = strobe_s[1];
   assign oe_s = strobe_s[0];

   bfc_wr_capture #(.AW(AW), .DW(DW), .MIN_PULSE(MIN_PULSE)) u_cap (
      .clk(clk), .rst_n(rst_n), .ce_s(ce_s), .we_s(we_s), .oe_s(oe_s),
      .lock(vlow), .addr(addr), .din(din),
      .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
   );

   bfc_cmd_decode #(.AW(AW), .DW(DW)) u_dec (
      .clk(clk), .rst_n(rst_n), .hv_ok(hv_ok), .lock(vlow),
      .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
      .mode(mode), .erase_go(erase_go), .prog_go(prog_go),
      .prog_addr(prog_addr), .prog_data(prog_data)
   );

   bfc_array_model #(.DW(DW), .DEPTH(DEPTH)) u_arr (
      .clk(clk), .rst_n(rst_n), .erase_go(erase_go), .prog_go(prog_go),
      .prog_idx(prog_addr[IW-1:0]), .prog_data(prog_data),
      .rd_idx(addr[IW-1:0]), .rd_data(arr_rd)
   );

   always_comb begin
      if (mode == M_IDENT) begin
         if (addr[AW-1:1] != '0) rd_mux = '0;
         else                    rd_mux = addr[0] ? DEV_CODE : MFR_CODE;
      end else begin
         rd_mux = arr_rd;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             dout <= '0;
      else if (!ce_s && !oe_s) dout <= rd_mux;
      else                    dout <= '0;
   end

   assign mode_o = mode;
endmodule

// File: rtl/bfc_checker.sv
module bfc_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       hv_ok,
   input logic       vlow,
   input logic [1:0] mode_o,
   input logic       erase_go,
   input logic       prog_go
);
   p_hv_low_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !hv_ok |=> mode_o == 2'b00);
   p_hv_low_no_launch_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !hv_ok |=> !erase_go && !prog_go);
   p_lock_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
      vlow |=> mode_o == 2'b00 && !erase_go && !prog_go);
   p_erase_after_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
      erase_go |-> $past(mode_o) == 2'b10);
   p_erase_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      erase_go |=> !erase_go);
   p_prog_after_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
      prog_go |-> $past(mode_o) == 2'b11);
   p_launch_to_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_go || prog_go) |-> mode_o == 2'b00);
   p_launch_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(erase_go && prog_go));
endmodule

bind bulkflash_cmd_ctrl bfc_checker u_chk (
   .clk(clk), .rst_n(rst_n), .hv_ok(hv_ok), .vlow(vlow),
   .mode_o(mode_o), .erase_go(erase_go), .prog_go(prog_go)
);

// File: tb/sim_bulkflash_cmd_ctrl.sv
module sim_bulkflash_cmd_ctrl;
   localparam int AW = 16;
   localparam int DW = 8;
   localparam int DEPTH = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          hv_ok = 1'b1, vlow = 1'b0;
   logic          ce_n = 1'b0, we_n = 1'b0, oe_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] din = 8'h90;
   logic [DW-1:0] dout;
   logic [1:0]    mode_o;
   logic          erase_go, prog_go;
   logic [AW-1:0] prog_addr;
   logic [DW-1:0] prog_data;

   int total = 0, bad = 0, n_erase = 0, n_prog = 0;
   bit done = 0;
   logic [7:0] ref_mem [DEPTH];
   logic [1:0] ref_mode;

   always #4 clk = ~clk;

   bulkflash_cmd_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .hv_ok(hv_ok), .vlow(vlow),
      .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr), .din(din),
      .dout(dout), .mode_o(mode_o), .erase_go(erase_go), .prog_go(prog_go),
      .prog_addr(prog_addr), .prog_data(prog_data)
   );

   always @(posedge clk) begin
      if (erase_go) n_erase++;
      if (prog_go)  n_prog++;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; din = d; ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1;
      wait_n(2); we_n = 1'b0;
      wait_n(5); we_n = 1'b1;
      wait_n(4); ce_n = 1'b1;
      wait_n(6);
   endtask

   task automatic bus_read(input logic [15:0] a, output logic [7:0] v);
      @(negedge clk);
      addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
      wait_n(6);
      v = dout;
      ce_n = 1'b1; oe_n = 1'b1;
      wait_n(2);
   endtask

   function automatic logic [7:0] exp_read(input logic [15:0] a);
      if (ref_mode == 2'b01) return (a == 0) ? 8'h01 : (a == 1) ? 8'h25 : 8'h00;
      return ref_mem[a[3:0]];
   endfunction

   function automatic logic [1:0] ref_decode(input logic [7:0] c);
      case (c)
         8'h80, 8'h90: return 2'b01;
         8'h30:        return 2'b10;
         8'h10, 8'h50: return 2'b11;
         default:      return 2'b00;
      endcase
   endfunction

   task automatic ref_write(input logic [15:0] a, input logic [7:0] d);
      if (ref_mode == 2'b11) begin
         ref_mem[a[3:0]] = ref_mem[a[3:0]] & d;
         ref_mode = 2'b00;
      end else if (ref_mode == 2'b10) begin
         if (d == 8'h30) for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
         ref_mode = 2'b00;
      end else begin
         ref_mode = ref_decode(d);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      int pe, pp;
      void'($urandom(32'd1234));
      for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
      ref_mode = 2'b00;
      // R10: a write with code 90h is open across reset release
      wait_n(5); rst_n = 1'b1;
      wait_n(5); we_n = 1'b1;
      wait_n(3); ce_n = 1'b1;
      wait_n(8);
      chk("R10 open cycle at power-up ignored", mode_o, 2'b00);
      chk("R10 no launch", n_erase + n_prog, 0);

      bus_read(16'd3, v); chk("R2 read after reset", v, 8'hFF);

      bus_write(16'd0, 8'h90); chk("R3 90h identify", mode_o, 2'b01);
      bus_read(16'd0, v); chk("R3 manufacturer code", v, 8'h01);
      bus_read(16'd1, v); chk("R3 device code", v, 8'h25);
      bus_read(16'd2, v); chk("R3 other address", v, 8'h00);
      bus_write(16'd0, 8'h00); chk("R2 00h read", mode_o, 2'b00);
      bus_write(16'd0, 8'h80); chk("R3 80h identify", mode_o, 2'b01);
      bus_write(16'd0, 8'hFF); chk("R2 FFh read", mode_o, 2'b00);

      bus_write(16'd0, 8'h10); chk("R5 10h arms program", mode_o, 2'b11);
      bus_write(16'd5, 8'hA5);
      chk("R5 one program launch", n_prog, 1);
      chk("R5 back to read", mode_o, 2'b00);
      bus_read(16'd5, v); chk("R5 programmed byte", v, 8'hA5);
      bus_write(16'd0, 8'h50); bus_write(16'd5, 8'h0F);
      bus_read(16'd5, v); chk("R5 AND of old and new", v, 8'h05);

      pp = n_prog;
      bus_write(16'd0, 8'h10); bus_write(16'd5, 8'hFF);
      chk("R8 FFh consumed as data", n_prog, pp + 1);
      chk("R8 mode after first FFh", mode_o, 2'b00);
      bus_read(16'd5, v); chk("R8 byte unchanged", v, 8'h05);
      bus_write(16'd0, 8'hFF); chk("R8 second FFh read", mode_o, 2'b00);

      bus_write(16'd0, 8'h30); chk("R4 first 30h arms only", mode_o, 2'b10);
      chk("R4 no erase from setup", n_erase, 0);
      bus_write(16'd0, 8'h00); chk("R4 abort to read", mode_o, 2'b00);
      bus_read(16'd5, v); chk("R4 abort keeps data", v, 8'h05);
      bus_write(16'd0, 8'h30); bus_write(16'd0, 8'h30);
      chk("R4 one erase launch", n_erase, 1);
      chk("R4 read after erase", mode_o, 2'b00);
      for (int i = 0; i < DEPTH; i++) begin
         bus_read(16'(i), v); chk("R4 byte erased", v, 8'hFF);
      end

      pe = n_erase; pp = n_prog;
      bus_write(16'd0, 8'h80); bus_write(16'd0, 8'h42);
      chk("R12 unknown code to read", mode_o, 2'b00);
      chk("R12 no launch", n_erase + n_prog, pe + pp);

      hv_ok = 1'b0;
      bus_write(16'd0, 8'h90); chk("R1 write ignored without voltage", mode_o, 2'b00);
      bus_write(16'd0, 8'h10); bus_write(16'd2, 8'h00);
      chk("R1 no program launch", n_prog, pp);
      bus_read(16'd2, v); chk("R1 array untouched", v, 8'hFF);
      hv_ok = 1'b1;
      bus_write(16'd0, 8'h90); hv_ok = 1'b0; wait_n(3);
      chk("R1 drop forces read", mode_o, 2'b00);
      hv_ok = 1'b1; wait_n(2);

      bus_write(16'd0, 8'h90); vlow = 1'b1; wait_n(3);
      chk("R9 lockout forces read", mode_o, 2'b00);
      bus_write(16'd0, 8'h90); chk("R9 write ignored in lockout", mode_o, 2'b00);
      vlow = 1'b0; wait_n(4);
      bus_write(16'd0, 8'h90); chk("R9 accepted after lockout", mode_o, 2'b01);
      bus_write(16'd0, 8'h00);

      // R7: OE low during the cycle
      @(negedge clk); addr = 0; din = 8'h90; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
      wait_n(2); we_n = 1'b0; wait_n(5); we_n = 1'b1; wait_n(3); ce_n = 1'b1; oe_n = 1'b1; wait_n(6);
      chk("R7 OE low ignored", mode_o, 2'b00);
      // R7: CE high during the cycle
      @(negedge clk); ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b0; wait_n(5); we_n = 1'b1; wait_n(6);
      chk("R7 CE high ignored", mode_o, 2'b00);

      // R11: one-clock write-enable dip
      @(negedge clk); din = 8'h90; ce_n = 1'b0; oe_n = 1'b1; wait_n(2);
      we_n = 1'b0; wait_n(1); we_n = 1'b1; wait_n(3); ce_n = 1'b1; wait_n(6);
      chk("R11 short pulse discarded", mode_o, 2'b00);
      bus_write(16'd0, 8'h90); chk("R11 full pulse accepted", mode_o, 2'b01);
      bus_write(16'd0, 8'h00);

      // R6: address moves and data moves inside one program cycle
      bus_write(16'd0, 8'h10);
      @(negedge clk); addr = 16'd7; din = 8'hF0; ce_n = 1'b0; oe_n = 1'b1; wait_n(2);
      we_n = 1'b0; wait_n(5); addr = 16'd9; din = 8'h3C; wait_n(3);
      we_n = 1'b1; wait_n(4); ce_n = 1'b1; wait_n(6);
      chk("R6 launch address from cycle start", prog_addr, 16'd7);
      chk("R6 launch data from cycle end", prog_data, 8'h3C);
      bus_read(16'd7, v); chk("R6 byte at first address", v, 8'h3C);
      bus_read(16'd9, v); chk("R6 later address untouched", v, 8'hFF);

      // random command mix against the bench model
      for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
      ref_mem[7] = 8'h3C;
      ref_mode = 2'b00;
      for (int it = 0; it < 80; it++) begin
         logic [7:0] d;
         logic [15:0] a;
         a = 16'($urandom % DEPTH);
         case ($urandom % 8)
            0: d = 8'h00; 1: d = 8'hFF; 2: d = 8'h80; 3: d = 8'h90;
            4: d = 8'h30; 5: d = 8'h10; 6: d = 8'h50;
            default: d = 8'($urandom);
         endcase
         if (ref_mode == 2'b11) d = 8'($urandom);
         bus_write(a, d);
         ref_write(a, d);
         chk("R2 R3 R4 R5 R12 random mode", mode_o, ref_mode);
         if (it % 3 == 0) begin
            a = (ref_mode == 2'b01) ? 16'($urandom % 4) : 16'($urandom % DEPTH);
            bus_read(a, v);
            chk("R2 R3 R5 random read", v, exp_read(a));
         end
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule